// File: doc/BRIEF.md
# Codec Serial Control and Sample Port

This block is the 16-bit full-duplex serial slave port of a voiceband codec. One serial link carries two kinds of traffic: configuration writes and PCM sample exchange. A tag line, sampled when a word begins, marks each word as one kind or the other. A configuration word picks one of four settings registers with its two top bits and stores its low fourteen bits there. A sample word shifts a new playback sample in while the most recent capture sample shifts out.

Everything runs on one system clock. The serial bit clock appears as a one-cycle enable `bit_en`. The codec's sample clock appears as a one-cycle enable `smp_tick`. Holding registers sit between the shift registers and the codec side, so the codec can deliver a capture sample and take a playback sample while a word is shifting. A status flag shows whether a new sample is waiting to be exchanged. Codec-side exchanges happen only while the enable bit of settings register 0 is set.

Top module: `codec_sio_port`

## Requirements
- R1: After reset, `status`, `sdo`, `dac_strobe`, `dac_sample` and all four settings registers are zero.
- R2: A word begins on a cycle with `bit_en` and `fsync` both high and no word in progress. On each of the next 16 `bit_en` cycles one bit is taken from `sdi` and one bit is shifted out on `sdo`, most significant bit first. `sdo` shows bit 15 before the first of these cycles.
- R3: When `sadd` is 1 on the start cycle, the word is a configuration write. Received bits 15:14 select the register (00 = `cfg_r0`, 01 = `cfg_r1`, 10 = `cfg_r2`, 11 = `cfg_r3`) and received bits 13:0 are stored in it. `sdo` shifts out zeros during such a word, and `status` is not changed by it.
- R4: When `sadd` is 0 on the start cycle, the word is a sample word. The received word goes to the incoming holding register. It appears on `dac_sample`, with a one-cycle `dac_strobe`, at the next enabled sample tick.
- R5: At the start of a sample word, the outgoing holding register is copied into the output shift register and sent on `sdo`. A sample tick in that same cycle writes the holding register, and the word being sent is the value from before that write.
- R6: An enabled sample tick loads `adc_sample` into the outgoing holding register, moves the incoming holding register to `dac_sample`, and sets `status` to 1.
- R7: `status` is cleared at the start cycle and at the final bit cycle of a sample word. When an enabled sample tick falls in the same cycle as either clear, `status` ends up 1.
- R8: The enable bit is `cfg_r0` bit 0. While it is 0, sample ticks have no effect: `dac_sample` holds its value, `dac_strobe` stays low, `status` is not set, and the outgoing holding register keeps its value.
- R9: While a word is in progress, `fsync` is ignored and the word is received intact.
- R10: A sample tick in the middle of a word does not disturb the bits being shifted in or out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle serial bit enable |
| fsync | input | 1 | Word start marker |
| sadd | input | 1 | Word tag: 1 = configuration, 0 = sample |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| smp_tick | input | 1 | One-cycle codec sample enable |
| adc_sample | input | 16 | Capture sample from the codec |
| dac_sample | output | 16 | Playback sample to the codec |
| dac_strobe | output | 1 | Pulse when `dac_sample` is updated |
| status | output | 1 | New sample waiting to be exchanged |
| cfg_r0 | output | 14 | Settings register 0 (bit 0 = enable) |
| cfg_r1 | output | 14 | Settings register 1 |
| cfg_r2 | output | 14 | Settings register 2 |
| cfg_r3 | output | 14 | Settings register 3 |

## Verification
Two functions can land in the same cycle: the sample tick, which sets `status` and reloads the outgoing holding register, and a sample word's start or final bit, which clears `status` and moves data between the shift and holding registers. The bench places a tick exactly on the start cycle, exactly on the final bit cycle, and in the middle of a word. It then checks that the bits sent are the pre-tick holding value, that the received word is unchanged, and that `status` comes out set.

// File: rtl/codec_sio_pkg.sv
package codec_sio_pkg;
  localparam int WORD_W   = 16;
  localparam int SEL_W    = 2;
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int FIELD_W  = WORD_W - SEL_W;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [SEL_W-1:0]   sel_t;

  typedef enum logic {XFER_DATA = 1'b0, XFER_CTRL = 1'b1} xfer_kind_e;

  function automatic sel_t word_sel(input word_t w);
    return w[WORD_W-1 -: SEL_W];
  endfunction

  function automatic field_t word_field(input word_t w);
    return w[FIELD_W-1:0];
  endfunction
endpackage

// File: rtl/sio_shifter.sv
module sio_shifter
  import codec_sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       fsync,
  input  logic       sadd,
  input  logic       sdi,
  input  word_t      tx_word,
  output logic       sdo,
  output logic       frame_start,
  output logic       frame_done,
  output xfer_kind_e frame_kind,
  output word_t      rx_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              busy;
  logic [CNT_W-1:0]  bits_left;
  logic [WORD_W-2:0] isr;
  word_t             osr;
  xfer_kind_e        kind_q;

  assign frame_start = bit_en && fsync && !busy;
  assign frame_done  = busy && bit_en && (bits_left == CNT_W'(1));
  assign rx_word     = {isr, sdi};
  assign sdo         = osr[WORD_W-1];
  assign frame_kind  = kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bits_left <= '0;
      isr       <= '0;
      osr       <= '0;
      kind_q    <= XFER_DATA;
    end else if (frame_start) begin
      busy      <= 1'b1;
      bits_left <= CNT_W'(WORD_W);
      kind_q    <= sadd ? XFER_CTRL : XFER_DATA;
      osr       <= tx_word;
    end else if (busy && bit_en) begin
      isr       <= {isr[WORD_W-3:0], sdi};
      osr       <= {osr[WORD_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
      if (bits_left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  // R2: a word cannot begin and end in the same cycle
  assert_start_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, frame_done}));

  // R10: shifting only advances on bit enables
  assert_shift_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> $stable(osr) && $stable(isr));

  // R9: fsync during a word does not restart it
  assert_fsync_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_en && fsync && bits_left > CNT_W'(1)) |=> busy);
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import codec_sio_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  word_t                      wr_word,
  output logic [NUM_REGS-1:0][FIELD_W-1:0] regs
);
  sel_t   wr_sel;
  field_t wr_field;

  assign wr_sel   = word_sel(wr_word);
  assign wr_field = word_field(wr_word);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               regs[g] <= '0;
      else if (wr_en && wr_sel == SEL_W'(g))    regs[g] <= wr_field;
    end

    // R3: a register changes only after a configuration word addressed to it
    assert_cfg_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs[g]) |-> ($past(wr_en) && $past(wr_sel) == SEL_W'(g)));
  end
endmodule

// File: rtl/sample_buf.sv
module sample_buf
  import codec_sio_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  smp_tick,
  input  word_t adc_sample,
  input  logic  data_start,
  input  logic  data_done,
  input  word_t rx_word,
  output word_t out_hold,
  output word_t dac_word,
  output logic  dac_strobe,
  output logic  status
);
  word_t in_hold;
  logic  tick_act;
  logic  status_clr;

  assign tick_act   = smp_tick && enable;
  assign status_clr = data_start || data_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hold   <= '0;
      in_hold    <= '0;
      dac_word   <= '0;
      dac_strobe <= 1'b0;
      status     <= 1'b0;
    end else begin
      dac_strobe <= tick_act;
      if (tick_act) begin
        out_hold <= adc_sample;
        dac_word <= in_hold;
      end
      if (data_done) in_hold <= rx_word;
      if (tick_act)        status <= 1'b1;
      else if (status_clr) status <= 1'b0;
    end
  end

  // R6: status rises only on an enabled sample tick
  assert_status_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(tick_act));

  // R7: status falls only at a sample word boundary
  assert_status_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> $past(status_clr));

  // R7: a tick coinciding with a clear leaves status set
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_act && status_clr) |=> status);

  // R8: playback output frozen while disabled
  assert_inactive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ($stable(dac_word) && !dac_strobe));
endmodule

// File: rtl/codec_sio_port.sv
module codec_sio_port
  import codec_sio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en,
  input  logic               fsync,
  input  logic               sadd,
  input  logic               sdi,
  output logic               sdo,
  input  logic               smp_tick,
  input  logic [WORD_W-1:0]  adc_sample,
  output logic [WORD_W-1:0]  dac_sample,
  output logic               dac_strobe,
  output logic               status,
  output logic [FIELD_W-1:0] cfg_r0,
  output logic [FIELD_W-1:0] cfg_r1,
  output logic [FIELD_W-1:0] cfg_r2,
  output logic [FIELD_W-1:0] cfg_r3
);
  localparam int ENABLE_BIT = 0;

  logic       frame_start;
  logic       frame_done;
  xfer_kind_e frame_kind;
  word_t      rx_word;
  word_t      tx_word;
  word_t      out_hold;
  logic       data_start;
  logic       data_done;
  logic       ctrl_done;
  logic       enable;
  logic [NUM_REGS-1:0][FIELD_W-1:0] regs;

  assign tx_word    = sadd ? '0 : out_hold;
  assign data_start = frame_start && !sadd;
  assign data_done  = frame_done && (frame_kind == XFER_DATA);
  assign ctrl_done  = frame_done && (frame_kind == XFER_CTRL);
  assign enable     = regs[0][ENABLE_BIT];

  assign cfg_r0 = regs[0];
  assign cfg_r1 = regs[1];
  assign cfg_r2 = regs[2];
  assign cfg_r3 = regs[3];

  sio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sadd(sadd),
    .sdi(sdi), .tx_word(tx_word), .sdo(sdo), .frame_start(frame_start),
    .frame_done(frame_done), .frame_kind(frame_kind), .rx_word(rx_word)
  );

  cfg_bank u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_done), .wr_word(rx_word), .regs(regs)
  );

  sample_buf u_buf (
    .clk(clk), .rst_n(rst_n), .enable(enable), .smp_tick(smp_tick),
    .adc_sample(adc_sample), .data_start(data_start), .data_done(data_done),
    .rx_word(rx_word), .out_hold(out_hold), .dac_word(dac_sample),
    .dac_strobe(dac_strobe), .status(status)
  );

  // R3: configuration words never touch the sample path status
  assert_ctrl_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_done && !(smp_tick && enable)) |=> $stable(status));
endmodule

// File: tb/tb_codec_sio_port.sv
module tb_codec_sio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, fsync = 1'b0, sadd = 1'b0, sdi = 1'b0;
  logic        smp_tick = 1'b0;
  logic [15:0] adc_sample = '0;
  logic        sdo, dac_strobe, status;
  logic [15:0] dac_sample;
  logic [13:0] cfg_r0, cfg_r1, cfg_r2, cfg_r3;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] m_out = '0, m_in = '0, m_dac = '0, m_osr = '0;
  logic        m_status = 1'b0, m_active = 1'b0;
  logic [13:0] m_cfg [4];

  always #4 clk = ~clk;

  codec_sio_port dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync), .sadd(sadd),
    .sdi(sdi), .sdo(sdo), .smp_tick(smp_tick), .adc_sample(adc_sample),
    .dac_sample(dac_sample), .dac_strobe(dac_strobe), .status(status),
    .cfg_r0(cfg_r0), .cfg_r1(cfg_r1), .cfg_r2(cfg_r2), .cfg_r3(cfg_r3)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [13:0] cfg_of(input int i);
    case (i)
      0: return cfg_r0;
      1: return cfg_r1;
      2: return cfg_r2;
      default: return cfg_r3;
    endcase
  endfunction

  // tick_pos: -1 none, 0 start cycle, 1..16 bit cycles (16 = final bit)
  task automatic xfer(input logic is_ctrl, input logic [15:0] tx, input int tick_pos,
                      input logic [15:0] tick_val, input logic fs_hold,
                      output logic [15:0] rx);
    for (int c = 0; c <= 16; c++) begin
      logic [15:0] old_in, old_out;
      logic        t_act;
      bit_en = 1'b1;
      fsync = (c == 0) || fs_hold;
      sadd = is_ctrl;
      sdi = (c > 0) ? tx[16-c] : 1'b0;
      smp_tick = (c == tick_pos);
      adc_sample = tick_val;
      if (c > 0) rx[16-c] = sdo;
      old_in = m_in;
      old_out = m_out;
      t_act = (c == tick_pos) && m_active;
      if (c == 0) begin
        m_osr = is_ctrl ? 16'h0 : old_out;
        if (!is_ctrl) m_status = 1'b0;
      end
      if (c == 16) begin
        if (!is_ctrl) begin
          m_in = tx;
          m_status = 1'b0;
        end else begin
          m_cfg[tx[15:14]] = tx[13:0];
          if (tx[15:14] == 2'b00) m_active = tx[0];
        end
      end
      if (t_act) begin
        m_dac = old_in;
        m_out = tick_val;
        m_status = 1'b1;
      end
      step();
    end
    bit_en = 1'b0;
    fsync = 1'b0;
    smp_tick = 1'b0;
  endtask

  task automatic tick(input logic [15:0] val, input string tag);
    logic t_act;
    smp_tick = 1'b1;
    adc_sample = val;
    t_act = m_active;
    if (t_act) begin
      m_dac = m_in;
      m_out = val;
      m_status = 1'b1;
    end
    step();
    smp_tick = 1'b0;
    chk({tag, " dac_sample"}, dac_sample, m_dac);
    chk({tag, " dac_strobe"}, dac_strobe, t_act);
    chk({tag, " status"}, status, m_status);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    for (int i = 0; i < 4; i++) m_cfg[i] = '0;
    repeat (3) step();
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 sdo", sdo, 0);
    chk("R1 dac_strobe", dac_strobe, 0);
    chk("R1 dac_sample", dac_sample, 0);
    for (int i = 0; i < 4; i++) chk("R1 cfg", cfg_of(i), 0);
    rst_n = 1'b1;
    step();

    // R3 configuration sweep over all registers, enable bit kept clear
    foreach (m_cfg[i]) begin
      logic [13:0] pats [4];
      pats[0] = 14'h3FFE; pats[1] = 14'h2AAA; pats[2] = 14'h1554; pats[3] = 14'h0000;
      for (int p = 0; p < 4; p++) begin
        logic [13:0] v;
        v = pats[p] ^ 14'(i * 14'h0113);
        v[0] = (i == 0) ? 1'b0 : v[0];
        xfer(1'b1, {2'(i), v}, -1, 16'h0, 1'b0, rx);
        chk("R3 ctrl sdo zeros", rx, 16'h0);
        for (int r = 0; r < 4; r++) chk("R3 cfg value", cfg_of(r), m_cfg[r]);
      end
    end

    // R8 ticks ignored while disabled
    tick(16'h1234, "R8 inactive tick");
    xfer(1'b0, 16'hBEEF, -1, 16'h0, 1'b0, rx);
    chk("R8 out hold unchanged", rx, 16'h0000);
    chk("R8 status", status, 0);

    // enable via cfg_r0 bit 0
    xfer(1'b1, 16'h0001, -1, 16'h0, 1'b0, rx);
    chk("R8 enable bit", cfg_r0, 14'h0001);

    // R6 / R4 / R5 basic exchange
    tick(16'h7FFF, "R6 tick");
    xfer(1'b0, 16'h8000, -1, 16'h0, 1'b0, rx);
    chk("R5 sent word", rx, m_osr);
    chk("R7 status after data word", status, m_status);
    tick(16'h0001, "R4 playback");

    // R2 / R4 / R5 walking ones sweep
    for (int i = 0; i < 16; i++) begin
      xfer(1'b0, 16'(1) << i, -1, 16'h0, 1'b0, rx);
      chk("R2 msb first rx", rx, m_osr);
      tick(~(16'(1) << i), "R4 walking");
    end

    // R3 control word leaves status alone
    xfer(1'b1, 16'h4ABC, -1, 16'h0, 1'b0, rx);
    chk("R3 status untouched", status, m_status);
    chk("R3 cfg_r1", cfg_r1, 14'h0ABC);

    // R7 / R5 tick on the start cycle
    xfer(1'b0, 16'hA5A5, 0, 16'hC3C3, 1'b0, rx);
    chk("R5 pre-tick word sent", rx, m_osr);
    chk("R7 status after end", status, m_status);
    xfer(1'b0, 16'h5A5A, -1, 16'h0, 1'b0, rx);
    chk("R5 tick value sent next", rx, 16'hC3C3);

    // R7 tick on the final bit cycle: set wins
    xfer(1'b0, 16'h1357, 16, 16'h2468, 1'b0, rx);
    chk("R7 set wins at done", status, 1);
    chk("R7 dac old in_hold", dac_sample, m_dac);

    // R10 tick mid-word
    xfer(1'b0, 16'hF00D, 8, 16'h0BAD, 1'b0, rx);
    chk("R10 tx intact", rx, m_osr);
    tick(16'h0, "R10 rx intact");

    // R9 fsync held through the word
    xfer(1'b0, 16'hCAFE, -1, 16'h0, 1'b1, rx);
    chk("R9 tx with fsync held", rx, m_osr);
    tick(16'h0, "R9 rx with fsync held");

    // R8 disable again then tick
    xfer(1'b1, 16'h0000, -1, 16'h0, 1'b0, rx);
    tick(16'h7777, "R8 disabled again");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule